// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This block sits on a 16-bit processor bus and decides, for every memory cycle, whether the boot ROM or main RAM answers. After reset a small boot ROM covers the bottom of the address space, so the processor's first fetch at address zero comes from ROM. Software later switches the ROM out by writing a control register that lives in I/O space. From then on the whole address space is RAM.

The overlay is asymmetric. While the ROM is mapped, memory reads inside the low window go to ROM. Memory writes to the same addresses always go to the RAM underneath. Boot code can therefore fill the RAM behind the ROM before it switches the ROM out.

The control register is 8 bits wide. Bit 0 is the overlay switch. The other seven bits are only stored and read back, for neighbouring logic to use. The chip selects are purely combinational from the bus. Only the control register is clocked.

Top module: `ovl_mem_decode`

## Requirements
- R1: An active-low asynchronous reset clears the control register to 0x00. The ROM is then mapped, so an opcode fetch (memory read with M1 asserted) at 0x0000 selects ROM.
- R2: While bit 0 of the control register is 0, a memory read (mreq_i=1, iorq_i=0, rd_i=1, wr_i=0) at any address in 0x0000–0x0FFF asserts rom_cs_o and not ram_cs_o.
- R3: A memory write (mreq_i=1, iorq_i=0, wr_i=1, rd_i=0) inside 0x0000–0x0FFF asserts ram_cs_o and not rom_cs_o, whatever the value of bit 0.
- R4: A memory read or write at 0x1000–0xFFFF asserts ram_cs_o and never rom_cs_o, whatever the value of bit 0.
- R5: While bit 0 is 1, memory reads in 0x0000–0x0FFF select RAM. Writing bit 0 back to 0 maps the ROM in again.
- R6: An I/O write (iorq_i=1, wr_i=1, rd_i=0, m1_i=0, mreq_i=0) whose low address byte is 0x00 loads all 8 bits of data_i into the control register on the rising clock edge. The upper address byte is ignored. ctrl_q_o shows the value from that edge on.
- R7: I/O writes to any other low address byte, and all other cycle types, leave the control register unchanged.
- R8: rom_cs_o and ram_cs_o are never high together. Neither is high on I/O cycles, on interrupt acknowledge (iorq_i=1 with m1_i=1), or on memory cycles that have neither rd_i nor wr_i.
- R9: ctrl_wr_o is high, combinationally, exactly while an R6 control-register write is on the bus.
- R10: A memory cycle with rd_i and wr_i both high selects neither device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Address bus |
| data_i | input | 8 | Data bus, written into the control register |
| mreq_i | input | 1 | Memory request, active high |
| iorq_i | input | 1 | I/O request, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| m1_i | input | 1 | Opcode fetch / interrupt acknowledge marker |
| rom_cs_o | output | 1 | ROM chip select |
| ram_cs_o | output | 1 | RAM chip select |
| ctrl_wr_o | output | 1 | Control-register write strobe |
| ctrl_q_o | output | 8 | Control-register read-back |

## Verification
Both chip selects and the write strobe follow the bus in the same cycle. The bench drives each bus pattern on a falling edge and checks these outputs 5 ns later, before the next rising edge. The control register loads on the first rising edge of an I/O write to port 0x00. The bench removes the write on the following falling edge and reads ctrl_q_o after that, so the check never races the edge. Reset clearing is checked while reset is still low, with no clock edge in between.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_wr;
    logic int_ack;
  } cyc_t;
endpackage

// File: rtl/ovl_cycle_dec.sv
module ovl_cycle_dec
  import ovl_pkg::*;
#(
  parameter int PORT_AW   = 8,
  parameter int CTRL_PORT = 0
) (
  input  logic [PORT_AW-1:0] port_i,
  input  logic               mreq_i,
  input  logic               iorq_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               m1_i,
  output cyc_t               cyc_o,
  output logic               ctrl_wr_o
);
  localparam logic [PORT_AW-1:0] PortMatch = PORT_AW'(CTRL_PORT);

  logic io_cyc;
  logic port_hit;

  always_comb begin
    io_cyc         = iorq_i && !mreq_i && !m1_i;
    port_hit       = (port_i == PortMatch);
    cyc_o.mem_rd   = mreq_i && !iorq_i && rd_i && !wr_i;
    cyc_o.mem_wr   = mreq_i && !iorq_i && wr_i && !rd_i;
    cyc_o.io_wr    = io_cyc && wr_i && !rd_i;
    cyc_o.int_ack  = iorq_i && m1_i;
    ctrl_wr_o      = cyc_o.io_wr && port_hit;
  end
endmodule

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg #(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));  // R6
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));  // R7
endmodule

// File: rtl/ovl_cs_steer.sv
module ovl_cs_steer
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-ROM_AW-1:0] page_i,
  input  cyc_t                     cyc_i,
  input  logic                     rom_off_i,
  output logic                     rom_cs_o,
  output logic                     ram_cs_o
);
  logic in_win;
  logic rom_view;

  always_comb begin
    in_win   = ~|page_i;
    rom_view = in_win && !rom_off_i;
    rom_cs_o = cyc_i.mem_rd && rom_view;
    // writes fall through to RAM even under the ROM
    ram_cs_o = cyc_i.mem_wr || (cyc_i.mem_rd && !rom_view);
  end

  AST_WIN_WRITE_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i.mem_wr |-> (ram_cs_o && !rom_cs_o));  // R3
  AST_ROM_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_cs_o |-> in_win);  // R4
  AST_NO_CS_ON_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i.io_wr || cyc_i.int_ack) |-> (!rom_cs_o && !ram_cs_o));  // R8
endmodule

// File: rtl/ovl_mem_decode.sv
module ovl_mem_decode
  import ovl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_AW    = 12,
  parameter int PORT_AW   = 8,
  parameter int CTRL_PORT = 0,
  parameter int OVL_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mreq_i,
  input  logic              iorq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              m1_i,
  output logic              rom_cs_o,
  output logic              ram_cs_o,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] ctrl_q_o
);
  localparam logic [ADDR_W-1:0] WinTop = ADDR_W'((1 << ROM_AW) - 1);

  cyc_t cyc;
  logic rom_off;

  ovl_cycle_dec #(.PORT_AW(PORT_AW), .CTRL_PORT(CTRL_PORT)) u_cycle_dec (
    .port_i   (addr_i[PORT_AW-1:0]),
    .mreq_i   (mreq_i),
    .iorq_i   (iorq_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .m1_i     (m1_i),
    .cyc_o    (cyc),
    .ctrl_wr_o(ctrl_wr_o)
  );

  ovl_ctrl_reg #(.DATA_W(DATA_W), .RST_VAL('0)) u_ctrl_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (ctrl_wr_o),
    .d_i   (data_i),
    .q_o   (ctrl_q_o)
  );

  assign rom_off = ctrl_q_o[OVL_BIT];

  ovl_cs_steer #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_cs_steer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .page_i   (addr_i[ADDR_W-1:ROM_AW]),
    .cyc_i    (cyc),
    .rom_off_i(rom_off),
    .rom_cs_o (rom_cs_o),
    .ram_cs_o (ram_cs_o)
  );

  AST_CS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_cs_o && ram_cs_o));  // R8
  AST_ROM_READ_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && !iorq_i && rd_i && !wr_i && addr_i <= WinTop && !ctrl_q_o[OVL_BIT])
      |-> rom_cs_o);  // R2
  AST_HIGH_IS_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && !iorq_i && (rd_i != wr_i) && addr_i > WinTop) |-> (ram_cs_o && !rom_cs_o));  // R4
  AST_RD_WR_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |-> (!rom_cs_o && !ram_cs_o));  // R10
  AST_STB_IO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |-> (iorq_i && wr_i && !m1_i && !mreq_i));  // R9
endmodule

// File: tb/ovl_mem_decode_bench.sv
module ovl_mem_decode_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        mreq = 0, iorq = 0, rd = 0, wr = 0, m1 = 0;
  logic        rom_cs, ram_cs, ctrl_wr;
  logic [7:0]  ctrl_q;
  int          n_chk = 0;
  int          n_err = 0;

  always #10 clk = ~clk;

  ovl_mem_decode u_ovl_mem_decode (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(data),
    .mreq_i(mreq), .iorq_i(iorq), .rd_i(rd), .wr_i(wr), .m1_i(m1),
    .rom_cs_o(rom_cs), .ram_cs_o(ram_cs), .ctrl_wr_o(ctrl_wr), .ctrl_q_o(ctrl_q)
  );

  // {rom_off, mreq,iorq,rd,wr,m1, addr, exp_rom,exp_ram,exp_stb}
  localparam int NV = 15;
  localparam logic [24:0] VECS [NV] = '{
    {1'b0, 5'b10101, 16'h0000, 3'b100},  // R2 fetch
    {1'b0, 5'b10100, 16'h0FFF, 3'b100},  // R2 top of window
    {1'b0, 5'b10010, 16'h0800, 3'b010},  // R3
    {1'b0, 5'b10100, 16'h1000, 3'b010},  // R4
    {1'b0, 5'b10010, 16'hFFFF, 3'b010},  // R4
    {1'b0, 5'b01100, 16'h0000, 3'b000},  // R8 io read
    {1'b0, 5'b01001, 16'h0000, 3'b000},  // R8 int ack
    {1'b0, 5'b10000, 16'h0000, 3'b000},  // R8 no strobe
    {1'b0, 5'b10110, 16'h0000, 3'b000},  // R10
    {1'b1, 5'b10101, 16'h0000, 3'b010},  // R5
    {1'b1, 5'b10100, 16'h0FFF, 3'b010},  // R5
    {1'b1, 5'b10010, 16'h0004, 3'b010},  // R3
    {1'b1, 5'b10100, 16'h1000, 3'b010},  // R4
    {1'b1, 5'b01010, 16'h0001, 3'b000},  // R9 other port
    {1'b1, 5'b01010, 16'h1200, 3'b001}   // R9 port 0x00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    mreq = 0; iorq = 0; rd = 0; wr = 0; m1 = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    idle(); iorq = 1; wr = 1; addr = a; data = d;
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic mem_cyc(input logic [4:0] ctl, input logic [15:0] a);
    @(negedge clk);
    {mreq, iorq, rd, wr, m1} = ctl; addr = a;
    #5;
  endtask

  initial begin
    #(20 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic cur_off;
    repeat (3) @(negedge clk);
    chk("R1 reset value", ctrl_q, 8'h00);
    rst_ni = 1'b1;
    mem_cyc(5'b10101, 16'h0000);
    chk("R1 first fetch from ROM", {6'b0, rom_cs, ram_cs}, 8'h02);
    idle();

    cur_off = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VECS[i];
      if (v[24] != cur_off) begin
        io_write(16'h0000, {7'h0, v[24]});
        cur_off = v[24];
        chk("R6 overlay bit load", ctrl_q, {7'h0, cur_off});
      end
      data = {7'h0, cur_off};
      mem_cyc(v[23:19], v[18:3]);
      chk("R2-R5,R8,R10 selects", {6'b0, rom_cs, ram_cs}, {6'b0, v[2:1]});
      chk("R9 write strobe", {7'b0, ctrl_wr}, {7'b0, v[0]});
      @(negedge clk);
      idle();
    end

    io_write(16'h7F00, 8'hA5);
    chk("R6 full byte, upper addr ignored", ctrl_q, 8'hA5);
    mem_cyc(5'b10100, 16'h0100);
    chk("R5 ROM switched out", {6'b0, rom_cs, ram_cs}, 8'h01);
    idle();
    io_write(16'h0040, 8'h00);
    chk("R7 other port ignored", ctrl_q, 8'hA5);
    @(negedge clk);
    idle(); iorq = 1; m1 = 1; wr = 1; addr = 16'h0000; data = 8'h00;
    #5 chk("R9 no strobe on int ack", {7'b0, ctrl_wr}, 8'h00);
    @(negedge clk); idle(); #1;
    chk("R7 int ack ignored", ctrl_q, 8'hA5);
    io_write(16'h0000, 8'h5A);
    chk("R6 reload", ctrl_q, 8'h5A);
    mem_cyc(5'b10100, 16'h0FFE);
    chk("R5 ROM mapped again", {6'b0, rom_cs, ram_cs}, 8'h02);
    idle();
    io_write(16'h0000, 8'hFF);
    #3 rst_ni = 1'b0;
    #2 chk("R1 async reset clears", ctrl_q, 8'h00);
    #3 rst_ni = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule